// File: doc/BRIEF.md
# Two-Line Write-Through Byte Cache

This block is a small data cache between a processor's byte load/store port and a slow, byte-wide backing memory. It keeps two lines. Each line holds one two-byte block, and either line can hold any block. Every store is also sent on to memory, so memory is never stale and a line that is thrown out needs no write. A load or store that misses first fetches the whole block, one byte at a time, into a line. Only then is the access completed.

The processor raises `req_valid` with an address, a write flag and write data, and holds them until `rsp_done` pulses. For a load, `rsp_rdata` carries the addressed byte during that pulse. The memory port runs one transfer at a time. The cache holds `mem_rd` or `mem_wr` with `mem_addr` (and `mem_wdata`) steady until the memory returns a one-cycle `mem_ack`. Read data arrives in `mem_rdata` with that acknowledge. Two saturating counters report how many completed accesses hit and how many missed.

Top module: `wt_fa_cache`

## Requirements
- R1: After a synchronous active-high reset, both lines are invalid, both counters read zero, and `rsp_done`, `mem_rd` and `mem_wr` are low.
- R2: An address is 4 bits. Bits [3:1] are the tag and bit [0] picks the byte within the block. An access hits when a valid line carries the same tag.
- R3: A load that hits completes with `rsp_done` high in the cycle right after the request is first sampled, and it issues no memory transfer.
- R4: A miss reads the block from memory as exactly two byte reads, at address {tag,0} and then {tag,1}, and installs the block in a line.
- R5: Every store, hit or miss, issues exactly one memory byte write carrying the request's address and data, and it also updates the cached byte.
- R6: A store that misses fetches its block first (R4), then writes its byte into that line and to memory.
- R7: On a miss, an invalid line is filled first, with line 0 ahead of line 1. When both lines are valid, the least recently used line is replaced. The line that serves any access becomes the most recently used.
- R8: `rsp_done` is a single-cycle pulse per access. During the pulse of a load, `rsp_rdata` is the addressed byte, including data written by earlier stores.
- R9: When an access completes, the hit counter or the miss counter goes up by one. Each counter stops at its all-ones value instead of wrapping.
- R10: A replaced line is dropped without any memory write. `mem_wr` is asserted only while a store is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present, held until `rsp_done` |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 4 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Load data, valid with `rsp_done` |
| mem_rd | output | 1 | Memory byte read request, held until `mem_ack` |
| mem_wr | output | 1 | Memory byte write request, held until `mem_ack` |
| mem_addr | output | 4 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The assertions assume that the processor keeps a request steady until its done pulse, and that memory gives exactly one acknowledge per transfer and only while a transfer is pending. The fill-order and write-stability checks depend on both of these.

The stimulus meets these assumptions as follows:
- It raises a request only when the cache is idle and drops it on the falling edge after the done pulse.
- The bench's memory responder acknowledges a pending transfer after a fixed wait. It then clears the acknowledge on the next falling edge, before it looks at any new request.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W    = 4;
    localparam int OFF_W     = 1;
    localparam int TAG_W     = ADDR_W - OFF_W;
    localparam int BLK_BYTES = 1 << OFF_W;
    localparam int BYTE_W    = 8;
    // Replacement keeps one pointer bit, so the line count is fixed at two.
    localparam int LINES     = 2;
    localparam int WAY_W     = $clog2(LINES);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef byte_t [BLK_BYTES-1:0] block_t;

    typedef struct packed {
        logic   valid;
        tag_t   tag;
        block_t data;
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_STORE,
        ST_DONE
    } state_t;

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/wtc_sat_cnt.sv
module wtc_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != '1)
            count <= count + 1'b1;
    end

    // R9: a counter that is already full stays full.
    a_r9_hold_at_max: assert property (@(posedge clk) disable iff (rst)
        (count == '1) |=> (count == '1));

    // R9: an increment below the ceiling adds exactly one.
    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (inc && count != '1) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/wtc_match.sv
module wtc_match
    import wtc_pkg::*;
(
    input  line_t [LINES-1:0] lines_i,
    input  tag_t              tag_i,
    input  way_t              lru_i,
    output logic              hit_o,
    output way_t              hit_way_o,
    output way_t              victim_o
);
    logic [LINES-1:0] match;
    logic [LINES-1:0] empty;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = lines_i[g].valid && (lines_i[g].tag == tag_i);
        assign empty[g] = !lines_i[g].valid;
    end

    assign hit_o = |match;

    // Scanning from the top down leaves the lowest matching or empty line selected.
    always_comb begin
        hit_way_o = '0;
        victim_o  = lru_i;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_way_o = way_t'(i);
            if (empty[i]) victim_o  = way_t'(i);
        end
    end
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  way_t              fill_way,
    input  tag_t              fill_tag,
    input  block_t            fill_block,
    input  logic              wr_en,
    input  way_t              wr_way,
    input  off_t              wr_off,
    input  byte_t             wr_byte,
    output line_t [LINES-1:0] lines_o
);
    line_t q [LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                q[i] <= '0;
            end else begin
                if (fill_en && fill_way == way_t'(i)) begin
                    q[i].valid <= 1'b1;
                    q[i].tag   <= fill_tag;
                    q[i].data  <= fill_block;
                end
                if (wr_en && wr_way == way_t'(i))
                    q[i].data[wr_off] <= wr_byte;
            end
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_out
        assign lines_o[g] = q[g];
    end

    // R2: two valid lines never hold the same block.
    a_r2_unique_tags: assert property (@(posedge clk) disable iff (rst)
        (q[0].valid && q[1].valid) |-> (q[0].tag != q[1].tag));
endmodule

// File: rtl/wt_fa_cache.sv
module wt_fa_cache
    import wtc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [BYTE_W-1:0] rsp_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    state_t            state;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_we;
    byte_t             cur_wdata;
    logic              cur_hit;
    way_t              cur_way;
    way_t              lru;
    off_t              beat;
    block_t            fill_buf;
    block_t            fill_block;

    line_t [LINES-1:0] lines;
    logic              hit;
    way_t              hit_way;
    way_t              victim;

    logic fill_last;
    logic fill_en;
    logic wr_en;

    wtc_match u_match (
        .lines_i   (lines),
        .tag_i     (tag_of(req_addr)),
        .lru_i     (lru),
        .hit_o     (hit),
        .hit_way_o (hit_way),
        .victim_o  (victim)
    );

    assign fill_last = (beat == off_t'(BLK_BYTES - 1));
    assign fill_en   = (state == ST_FILL) && mem_ack && fill_last;
    assign wr_en     = (state == ST_STORE) && mem_ack;

    // The byte arriving now completes the block that is about to be installed.
    always_comb begin
        fill_block       = fill_buf;
        fill_block[beat] = mem_rdata;
    end

    wtc_lines u_lines (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en),
        .fill_way   (cur_way),
        .fill_tag   (tag_of(cur_addr)),
        .fill_block (fill_block),
        .wr_en      (wr_en),
        .wr_way     (cur_way),
        .wr_off     (off_of(cur_addr)),
        .wr_byte    (cur_wdata),
        .lines_o    (lines)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_we    <= 1'b0;
            cur_wdata <= '0;
            cur_hit   <= 1'b0;
            cur_way   <= '0;
            lru       <= '0;
            beat      <= '0;
            fill_buf  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cur_addr  <= req_addr;
                    cur_we    <= req_we;
                    cur_wdata <= req_wdata;
                    cur_hit   <= hit;
                    cur_way   <= hit ? hit_way : victim;
                    beat      <= '0;
                    if (!hit)
                        state <= ST_FILL;
                    else if (req_we)
                        state <= ST_STORE;
                    else
                        state <= ST_DONE;
                end
                ST_FILL: if (mem_ack) begin
                    fill_buf[beat] <= mem_rdata;
                    beat           <= beat + 1'b1;
                    if (fill_last)
                        state <= cur_we ? ST_STORE : ST_DONE;
                end
                ST_STORE: if (mem_ack) state <= ST_DONE;
                ST_DONE: begin
                    // With two lines, the line not used by this access becomes the LRU line.
                    lru   <= cur_way ^ way_t'(1);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (state == ST_FILL);
    assign mem_wr    = (state == ST_STORE);
    assign mem_addr  = (state == ST_FILL) ? {tag_of(cur_addr), beat} : cur_addr;
    assign mem_wdata = cur_wdata;
    assign rsp_done  = (state == ST_DONE);
    assign rsp_rdata = lines[cur_way].data[off_of(cur_addr)];

    wtc_sat_cnt #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .inc   (rsp_done && cur_hit),
        .count (hit_count)
    );

    wtc_sat_cnt #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .inc   (rsp_done && !cur_hit),
        .count (miss_count)
    );

    // R4: an acknowledged read of a byte that is not the last in the block is followed by a read of the next byte.
    a_r4_fill_sequence: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ack && mem_addr[OFF_W-1:0] != '1)
        |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R5: a pending write keeps its address and data until it is acknowledged.
    a_r5_write_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R10: memory writes occur only while a store is in progress.
    a_r10_write_only_for_store: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> cur_we);

    // R3: a load that hits completes in the next cycle.
    a_r3_hit_load_fast: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && hit && !req_we) |=> (rsp_done && !mem_rd && !mem_wr));

    // R8: the done signal is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/sim_wt_fa_cache.sv
`timescale 1ns/1ps
module sim_wt_fa_cache;
    localparam int CW  = 3;
    localparam int SAT = (1 << CW) - 1;
    localparam int MEM_WAIT = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_we;
    logic [3:0]    req_addr;
    logic [7:0]    req_wdata;
    logic          rsp_done;
    logic [7:0]    rsp_rdata;
    logic          mem_rd, mem_wr;
    logic [3:0]    mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_ack;
    logic [7:0]    mem_rdata;
    logic [CW-1:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    wt_fa_cache #(.CNT_W(CW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    int vecs = 0;
    int bad  = 0;

    logic [7:0] bmem [16];
    int log_wr[$];
    int log_addr[$];
    int log_data[$];

    // Behavioural reference model
    bit mv[2];
    int mt[2];
    int md[2][2];
    int mlru  = 0;
    int mhits = 0;
    int mmiss = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges each transfer after a fixed wait and records it.
    initial begin : responder
        int wc;
        wc = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wc = 0;
            end else if (!rst && (mem_rd || mem_wr)) begin
                wc++;
                if (wc >= MEM_WAIT) begin
                    mem_ack = 1'b1;
                    log_addr.push_back(int'(mem_addr));
                    if (mem_rd) begin
                        mem_rdata = bmem[mem_addr];
                        log_wr.push_back(0);
                        log_data.push_back(int'(bmem[mem_addr]));
                    end else begin
                        bmem[mem_addr] = mem_wdata;
                        log_wr.push_back(1);
                        log_data.push_back(int'(mem_wdata));
                    end
                end
            end
        end
    end

    // Compares every clock: no memory write may appear while a load is in progress.
    bit load_active = 1'b0;
    always @(negedge clk) begin
        if (load_active && mem_wr) chk(1'b0, "R10 write during load", 1, 0);
    end

    task automatic access(input bit we, input int addr, input int wd);
        int tg, off, way, cyc, nrd, nwr, exp_rd;
        bit hit;
        tg = addr >> 1;
        off = addr & 1;
        way = -1;
        for (int w = 0; w < 2; w++) if (mv[w] && mt[w] == tg) way = w;
        hit = (way >= 0);
        if (!hit) begin
            way = !mv[0] ? 0 : (!mv[1] ? 1 : mlru);
            mv[way] = 1'b1;
            mt[way] = tg;
            md[way][0] = int'(bmem[tg*2]);
            md[way][1] = int'(bmem[tg*2+1]);
        end
        if (we) md[way][off] = wd & 255;
        exp_rd = md[way][off];
        mlru = 1 - way;
        if (hit) mhits = (mhits < SAT) ? mhits + 1 : SAT;
        else     mmiss = (mmiss < SAT) ? mmiss + 1 : SAT;

        log_wr.delete(); log_addr.delete(); log_data.delete();
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = 4'(addr); req_wdata = 8'(wd);
        load_active = !we;
        cyc = 0;
        do begin
            @(posedge clk); #1;
            cyc++;
        end while (!rsp_done && cyc < 100);
        chk(rsp_done, "R8 done pulse seen", int'(rsp_done), 1);
        if (!we) chk(rsp_rdata == 8'(exp_rd), "R8 load data", int'(rsp_rdata), exp_rd);
        if (hit && !we) chk(cyc == 1, "R3 hit load latency", cyc, 1);
        @(negedge clk);
        req_valid = 1'b0;
        load_active = 1'b0;
        @(posedge clk); #1;
        chk(!rsp_done, "R8 single-cycle pulse", int'(rsp_done), 0);

        nrd = 0; nwr = 0;
        foreach (log_wr[i]) if (log_wr[i] != 0) nwr++; else nrd++;
        chk(nrd == (hit ? 0 : 2), "R4 R7 block reads per access", nrd, hit ? 0 : 2);
        chk(nwr == (we ? 1 : 0), "R5 R10 byte writes per access", nwr, we ? 1 : 0);
        if (!hit && nrd == 2) begin
            chk(log_addr[0] == tg*2,   "R4 first fill address",  log_addr[0], tg*2);
            chk(log_addr[1] == tg*2+1, "R4 second fill address", log_addr[1], tg*2+1);
        end
        if (we && nwr == 1) begin
            chk(log_wr[log_wr.size()-1] == 1, "R6 write follows fill", log_wr[log_wr.size()-1], 1);
            chk(log_addr[log_addr.size()-1] == addr, "R5 write address",
                log_addr[log_addr.size()-1], addr);
            chk(log_data[log_data.size()-1] == (wd & 255), "R5 write data",
                log_data[log_data.size()-1], wd & 255);
        end
        chk(int'(hit_count) == mhits,  "R9 hit counter",  int'(hit_count), mhits);
        chk(int'(miss_count) == mmiss, "R9 miss counter", int'(miss_count), mmiss);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        vecs++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) bmem[i] = 8'((i * 37 + 11) & 255);
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(hit_count == '0,  "R1 hit counter after reset",  int'(hit_count), 0);
        chk(miss_count == '0, "R1 miss counter after reset", int'(miss_count), 0);
        chk(!rsp_done,        "R1 done low after reset",     int'(rsp_done), 0);
        chk(!mem_rd && !mem_wr, "R1 memory idle after reset", int'({mem_rd, mem_wr}), 0);

        // R1 R7: cold misses fill line 0 and then line 1
        access(0, 1, 0);
        access(0, 7, 0);
        // R2 R5: store hit on the block at tag 0
        access(1, 0, 8'hAD);
        // R6 R7: store miss replaces the LRU line (tag 3)
        access(1, 5, 8'h3C);
        // R7 R10: load miss drops the line holding tag 0 with no write
        access(0, 10, 0);
        access(1, 5, 8'h5A);
        access(1, 10, 8'h77);
        // R5: reload of the dropped block returns the written-through byte
        access(0, 0, 0);
        access(0, 11, 0);
        access(0, 4, 0);
        // R9: repeated hits drive the hit counter to saturation
        for (int k = 0; k < 9; k++) access(0, (k & 1) ? 5 : 4, 0);
        chk(int'(hit_count) == SAT, "R9 hit counter saturates", int'(hit_count), SAT);
        // R9: misses drive the miss counter to saturation
        for (int k = 0; k < 4; k++) access(0, (k & 1) ? 14 : 2, 0);
        chk(int'(miss_count) == SAT, "R9 miss counter saturates", int'(miss_count), SAT);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule